// File: doc/BRIEF.md
# Block lock range manager

This block decides, for a flash device made of many erase blocks, which blocks software may program or erase. It keeps one contiguous window of unlocked blocks and a sticky lock-tight flag. A command decoder upstream feeds it already-parsed lock operations, each carrying one block address. The write-protect pin and the lock-feature enable pin are fed to it as levels. Every block outside the unlocked window counts as locked. When the lock-tight flag is set, those locked blocks count as lock-tight instead.

Two lookup ports run side by side. The request port takes the target block of a program or erase. One cycle later it answers whether the modification may go ahead, or whether it must be refused with a locked-block busy period. The query port returns a per-block lock status code one cycle later. It refuses the query while the device reports busy. The array itself, command byte parsing and the timing of the busy period are handled elsewhere. This block only raises the flag that such a period is needed.

Top module: `bprot_range_mgr`

## Requirements
- R1: After reset, every block is locked, lock-tight is clear, no unlock start is pending, and `rsp_valid` and `stat_valid` are low until a lookup is made.
- R2: `cmd_op` code 3 (unlock start) stores `cmd_blk` as a pending start. A following code 4 (unlock end) with `cmd_blk` not below that start unlocks exactly the blocks from start to end inclusive. Start equal to end unlocks a single block.
- R3: A successful unlock replaces the previous unlocked window entirely. Blocks that were only in the old window become locked.
- R4: An unlock end whose block is below the pending start is ignored, and so is an unlock end with no pending start. In both cases the existing lock state is unchanged, and any pending start is dropped.
- R5: `cmd_op` code 1 (lock all) returns every block to locked and drops a pending start. Codes 0, 5, 6 and 7 do nothing.
- R6: `cmd_op` code 2 (lock-tight) turns every locked block into lock-tight and leaves the unlocked window unlocked. While lock-tight is set, all commands (codes 1 to 4) are ignored.
- R7: A clock edge that samples `wp_n` low clears lock-tight, the unlocked window and any pending start, so every block becomes locked. Commands presented at such an edge are ignored.
- R8: A request presented with `req_valid` yields `rsp_valid` at the next edge. `rsp_grant` is high only if the block is unlocked and `wp_n` was high. `rsp_hold` (locked-block busy needed) is high only if `wp_n` was high and the block is locked or lock-tight. The two are never high together.
- R9: While `lock_en` is low, every block is reported and treated as unlocked. The stored window and lock-tight flag are kept, and they apply again when `lock_en` returns high.
- R10: A query presented with `qry_valid` yields `stat_valid` at the next edge. If `busy` was high at the query, `stat_reject` is high and `stat_code` is 0.
- R11: For an accepted query, `stat_code` bit 0 means unlocked, bit 1 means locked and bit 2 means lock-tight, with exactly one of the three set. Bit 3 is high when `wp_n` was low at the query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_en | input | 1 | Lock feature enable level; low makes all blocks unlocked |
| wp_n | input | 1 | Write-protect pin level, low = protect and lock reset |
| cmd_valid | input | 1 | Lock command strobe |
| cmd_op | input | 3 | Lock command code (1 lock all, 2 lock-tight, 3 unlock start, 4 unlock end) |
| cmd_blk | input | BLK_W | Block address carried by unlock start/end |
| req_valid | input | 1 | Program/erase request strobe |
| req_blk | input | BLK_W | Target block of the request |
| rsp_valid | output | 1 | Request answer valid |
| rsp_grant | output | 1 | Modification allowed |
| rsp_hold | output | 1 | Refused on lock; locked-block busy period needed |
| busy | input | 1 | Device busy level, rejects status queries |
| qry_valid | input | 1 | Lock status query strobe |
| qry_blk | input | BLK_W | Queried block |
| stat_valid | output | 1 | Status answer valid |
| stat_reject | output | 1 | Query refused because the device was busy |
| stat_code | output | 4 | Status bits: unlocked, locked, lock-tight, write-protect low |

## Verification
The bench sweeps every start/end pair of a 16-block configuration and probes every block after each pair. This catches windows that are off by one at either end or that drop the single-block case. It also catches reversed pairs that corrupt the window, or that the design applies as if the end were the start. Lock-tight is probed after lock-all, unlock and repeated lock-tight commands. A design that lets software escape the flag would show newly unlocked or relocked blocks there. Write-protect is held low while unlock commands arrive, then raised. A design that clears only on a wp_n edge, or that accepts commands while protected, would show an unlocked window afterwards. Further checks cover a disabled lock feature and a busy-time status query. They confirm that the window survives the disabled period and that a rejected query still returns its answer cycle with a zero code.

// File: rtl/bprot_pkg.sv
package bprot_pkg;

   localparam int OP_W   = 3;
   localparam int STAT_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP      = 3'd0,
      OP_LOCK_ALL = 3'd1,
      OP_TIGHT    = 3'd2,
      OP_UNLK_LO  = 3'd3,
      OP_UNLK_HI  = 3'd4
   } lk_op_e;

   typedef enum logic [1:0] {
      BS_OPEN   = 2'd0,
      BS_LOCKED = 2'd1,
      BS_TIGHT  = 2'd2
   } blk_state_e;

   function automatic logic [STAT_W-1:0] stat_encode(blk_state_e st, logic wp_low);
      logic [STAT_W-1:0] c;
      c    = '0;
      c[0] = (st == BS_OPEN);
      c[1] = (st == BS_LOCKED);
      c[2] = (st == BS_TIGHT);
      c[3] = wp_low;
      return c;
   endfunction

endpackage

// File: rtl/bprot_range_reg.sv
module bprot_range_reg
   import bprot_pkg::*;
#(
   parameter int BLK_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wp_n,
   input  logic                cmd_valid,
   input  logic [OP_W-1:0]     cmd_op,
   input  logic [BLK_W-1:0]    cmd_blk,
   output logic                rng_vld,
   output logic [BLK_W-1:0]    rng_lo,
   output logic [BLK_W-1:0]    rng_hi,
   output logic                tight_q
);

   logic             pend_vld;
   logic [BLK_W-1:0] pend_lo;
   lk_op_e           op;
   logic             cmd_live;

   assign op       = lk_op_e'(cmd_op);
   assign cmd_live = cmd_valid && !tight_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !wp_n) begin
         rng_vld  <= 1'b0;
         rng_lo   <= '0;
         rng_hi   <= '0;
         tight_q  <= 1'b0;
         pend_vld <= 1'b0;
         pend_lo  <= '0;
      end else if (cmd_live) begin
         case (op)
            OP_LOCK_ALL: begin
               rng_vld  <= 1'b0;
               pend_vld <= 1'b0;
            end
            OP_TIGHT: begin
               tight_q  <= 1'b1;
               pend_vld <= 1'b0;
            end
            OP_UNLK_LO: begin
               pend_lo  <= cmd_blk;
               pend_vld <= 1'b1;
            end
            OP_UNLK_HI: begin
               pend_vld <= 1'b0;
               if (pend_vld && (cmd_blk >= pend_lo)) begin
                  rng_lo  <= pend_lo;
                  rng_hi  <= cmd_blk;
                  rng_vld <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/bprot_classify.sv
module bprot_classify
   import bprot_pkg::*;
#(
   parameter int BLK_W = 12
) (
   input  logic             lock_en,
   input  logic [BLK_W-1:0] blk,
   input  logic             rng_vld,
   input  logic [BLK_W-1:0] rng_lo,
   input  logic [BLK_W-1:0] rng_hi,
   input  logic             tight_q,
   output blk_state_e       state
);

   logic in_win;

   assign in_win = rng_vld && (blk >= rng_lo) && (blk <= rng_hi);

   always_comb begin
      if (!lock_en || in_win) state = BS_OPEN;
      else if (tight_q)       state = BS_TIGHT;
      else                    state = BS_LOCKED;
   end

endmodule

// File: rtl/bprot_resp.sv
module bprot_resp
   import bprot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wp_n,
   input  logic              req_valid,
   input  blk_state_e        req_st,
   input  logic              busy,
   input  logic              qry_valid,
   input  blk_state_e        qry_st,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_hold,
   output logic              stat_valid,
   output logic              stat_reject,
   output logic [STAT_W-1:0] stat_code
);

   logic req_open;

   assign req_open = (req_st == BS_OPEN);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_grant   <= 1'b0;
         rsp_hold    <= 1'b0;
         stat_valid  <= 1'b0;
         stat_reject <= 1'b0;
         stat_code   <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= req_valid && wp_n && req_open;
         rsp_hold  <= req_valid && wp_n && !req_open;

         stat_valid  <= qry_valid;
         stat_reject <= qry_valid && busy;
         if (qry_valid && !busy) stat_code <= stat_encode(qry_st, !wp_n);
         else                    stat_code <= '0;
      end
   end

endmodule

// File: rtl/bprot_range_mgr.sv
module bprot_range_mgr
   import bprot_pkg::*;
#(
   parameter  int NUM_BLK = 4096,
   localparam int BLK_W   = $clog2(NUM_BLK)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock_en,
   input  logic              wp_n,
   input  logic              cmd_valid,
   input  logic [OP_W-1:0]   cmd_op,
   input  logic [BLK_W-1:0]  cmd_blk,
   input  logic              req_valid,
   input  logic [BLK_W-1:0]  req_blk,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_hold,
   input  logic              busy,
   input  logic              qry_valid,
   input  logic [BLK_W-1:0]  qry_blk,
   output logic              stat_valid,
   output logic              stat_reject,
   output logic [STAT_W-1:0] stat_code
);

   localparam int N_PORT = 2;

   generate
      if (NUM_BLK < 2) begin : g_bad_count
         $error("bprot_range_mgr: NUM_BLK must be at least 2");
      end
      if ((NUM_BLK & (NUM_BLK - 1)) != 0) begin : g_bad_pow2
         $error("bprot_range_mgr: NUM_BLK must be a power of two");
      end
   endgenerate

   logic             rng_vld;
   logic [BLK_W-1:0] rng_lo;
   logic [BLK_W-1:0] rng_hi;
   logic             tight_q;

   bprot_range_reg #(.BLK_W(BLK_W)) u_range (
      .clk       (clk),
      .rst_n     (rst_n),
      .wp_n      (wp_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_blk   (cmd_blk),
      .rng_vld   (rng_vld),
      .rng_lo    (rng_lo),
      .rng_hi    (rng_hi),
      .tight_q   (tight_q)
   );

   logic [BLK_W-1:0] lk_blk [N_PORT];
   blk_state_e       lk_st  [N_PORT];

   assign lk_blk[0] = req_blk;
   assign lk_blk[1] = qry_blk;

   for (genvar g = 0; g < N_PORT; g++) begin : g_port
      bprot_classify #(.BLK_W(BLK_W)) u_cls (
         .lock_en (lock_en),
         .blk     (lk_blk[g]),
         .rng_vld (rng_vld),
         .rng_lo  (rng_lo),
         .rng_hi  (rng_hi),
         .tight_q (tight_q),
         .state   (lk_st[g])
      );
   end

   bprot_resp u_resp (
      .clk         (clk),
      .rst_n       (rst_n),
      .wp_n        (wp_n),
      .req_valid   (req_valid),
      .req_st      (lk_st[0]),
      .busy        (busy),
      .qry_valid   (qry_valid),
      .qry_st      (lk_st[1]),
      .rsp_valid   (rsp_valid),
      .rsp_grant   (rsp_grant),
      .rsp_hold    (rsp_hold),
      .stat_valid  (stat_valid),
      .stat_reject (stat_reject),
      .stat_code   (stat_code)
   );

endmodule

// File: rtl/bprot_chk.sv
module bprot_chk #(
   parameter int BLK_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lock_en,
   input logic             wp_n,
   input logic             req_valid,
   input logic             rsp_valid,
   input logic             rsp_grant,
   input logic             rsp_hold,
   input logic             busy,
   input logic             qry_valid,
   input logic             stat_valid,
   input logic             stat_reject,
   input logic [3:0]       stat_code,
   input logic             tight_q,
   input logic             rng_vld,
   input logic [BLK_W-1:0] rng_lo,
   input logic [BLK_W-1:0] rng_hi
);

   a_r4_window_order: assert property (@(posedge clk) disable iff (!rst_n)
      rng_vld |-> (rng_lo <= rng_hi));

   a_r6_tight_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tight_q && wp_n) |=> tight_q);

   a_r6_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (tight_q && wp_n) |=> ($stable(rng_vld) && $stable(rng_lo) && $stable(rng_hi)));

   a_r7_wp_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_n |=> (!tight_q && !rng_vld));

   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !(rsp_grant && rsp_hold));

   a_r8_wp_refuse: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !wp_n) |=> (rsp_valid && !rsp_grant && !rsp_hold));

   a_r9_disabled_open: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !lock_en && wp_n) |=> rsp_grant);

   a_r10_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && busy) |=> (stat_valid && stat_reject && (stat_code == 4'd0)));

   a_r11_one_state: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && !stat_reject) |-> ($countones(stat_code[2:0]) == 1));

endmodule

bind bprot_range_mgr bprot_chk #(.BLK_W(BLK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .lock_en     (lock_en),
   .wp_n        (wp_n),
   .req_valid   (req_valid),
   .rsp_valid   (rsp_valid),
   .rsp_grant   (rsp_grant),
   .rsp_hold    (rsp_hold),
   .busy        (busy),
   .qry_valid   (qry_valid),
   .stat_valid  (stat_valid),
   .stat_reject (stat_reject),
   .stat_code   (stat_code),
   .tight_q     (tight_q),
   .rng_vld     (rng_vld),
   .rng_lo      (rng_lo),
   .rng_hi      (rng_hi)
);

// File: tb/tb_bprot_range_mgr.sv
`timescale 1ns/1ps
module tb_bprot_range_mgr;

   localparam int NB = 16;
   localparam int BW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lock_en = 1'b1;
   logic          wp_n = 1'b1;
   logic          cmd_valid = 1'b0;
   logic [2:0]    cmd_op = 3'd0;
   logic [BW-1:0] cmd_blk = '0;
   logic          req_valid = 1'b0;
   logic [BW-1:0] req_blk = '0;
   logic          rsp_valid, rsp_grant, rsp_hold;
   logic          busy = 1'b0;
   logic          qry_valid = 1'b0;
   logic [BW-1:0] qry_blk = '0;
   logic          stat_valid, stat_reject;
   logic [3:0]    stat_code;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // bench-side model of the lock state
   bit m_rv, m_tight, m_pv;
   int m_lo, m_hi, m_plo;

   always #10 clk = ~clk;

   bprot_range_mgr #(.NUM_BLK(NB)) dut (
      .clk(clk), .rst_n(rst_n), .lock_en(lock_en), .wp_n(wp_n),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
      .req_valid(req_valid), .req_blk(req_blk),
      .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_hold(rsp_hold),
      .busy(busy), .qry_valid(qry_valid), .qry_blk(qry_blk),
      .stat_valid(stat_valid), .stat_reject(stat_reject), .stat_code(stat_code)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic model_clear();
      m_rv = 0; m_tight = 0; m_pv = 0;
   endtask

   // 0 unlocked, 1 locked, 2 lock-tight
   function automatic int exp_class(int b);
      if (!lock_en) return 0;
      if (m_rv && b >= m_lo && b <= m_hi) return 0;
      if (m_tight) return 2;
      return 1;
   endfunction

   task automatic send_cmd(input int op, input int blk);
      cmd_valid = 1'b1;
      cmd_op    = op[2:0];
      cmd_blk   = blk[BW-1:0];
      @(negedge clk);
      cmd_valid = 1'b0;
      if (!wp_n) model_clear();
      else if (!m_tight) begin
         case (op)
            1: begin m_rv = 0; m_pv = 0; end
            2: begin m_tight = 1; m_pv = 0; end
            3: begin m_plo = blk; m_pv = 1; end
            4: begin
               if (m_pv && blk >= m_plo) begin m_lo = m_plo; m_hi = blk; m_rv = 1; end
               m_pv = 0;
            end
            default: ;
         endcase
      end
   endtask

   task automatic unlock(input int lo, input int hi);
      send_cmd(3, lo);
      send_cmd(4, hi);
   endtask

   task automatic probe(input string tag, input int b);
      int cls;
      int code;
      cls  = exp_class(b);
      code = (cls == 0 ? 1 : 0) | (cls == 1 ? 2 : 0) | (cls == 2 ? 4 : 0) | (!wp_n ? 8 : 0);
      req_valid = 1'b1; req_blk = b[BW-1:0];
      qry_valid = 1'b1; qry_blk = b[BW-1:0];
      @(negedge clk);
      req_valid = 1'b0; qry_valid = 1'b0;
      if (!wp_n) model_clear();
      chk($sformatf("%s R8 blk%0d rsp_valid", tag, b), rsp_valid, 1);
      chk($sformatf("%s R8 blk%0d grant", tag, b), rsp_grant, (wp_n && cls == 0) ? 1 : 0);
      chk($sformatf("%s R8 blk%0d hold", tag, b), rsp_hold, (wp_n && cls != 0) ? 1 : 0);
      chk($sformatf("%s R10 blk%0d stat_valid", tag, b), stat_valid, 1);
      chk($sformatf("%s R10 blk%0d reject", tag, b), stat_reject, busy ? 1 : 0);
      chk($sformatf("%s R11 blk%0d code", tag, b), stat_code, busy ? 0 : code);
   endtask

   task automatic check_all(input string tag);
      for (int b = 0; b < NB; b++) probe(tag, b);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      model_clear();
      m_lo = 0; m_hi = 0; m_plo = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid idle", rsp_valid, 0);
      chk("R1 stat_valid idle", stat_valid, 0);
      check_all("R1");

      unlock(3, 9);   check_all("R2 3..9");
      unlock(5, 5);   check_all("R2 R3 single 5");
      unlock(12, 15); check_all("R3 12..15");
      unlock(10, 4);  check_all("R4 reversed");
      send_cmd(4, 8); check_all("R4 end alone");
      send_cmd(5, 0); send_cmd(0, 0); check_all("R5 no-op codes");
      send_cmd(1, 0); check_all("R5 lock all");
      send_cmd(3, 2); send_cmd(1, 0); send_cmd(4, 6); check_all("R5 pending dropped");

      unlock(2, 6);
      send_cmd(2, 0); check_all("R6 tight");
      send_cmd(1, 0); unlock(0, 15); send_cmd(2, 0); check_all("R6 frozen");

      lock_en = 1'b0; check_all("R9 disabled");
      lock_en = 1'b1; check_all("R9 restored");

      wp_n = 1'b0;
      @(negedge clk); model_clear();
      check_all("R7 wp low");
      unlock(0, 15);
      wp_n = 1'b1;
      check_all("R7 after wp pulse");

      unlock(1, 4);
      busy = 1'b1; probe("R10 busy", 2); probe("R10 busy", 9);
      busy = 1'b0; probe("R10 idle", 2);

      send_cmd(1, 0);
      for (int lo = 0; lo < NB; lo++) begin
         for (int hi = 0; hi < NB; hi++) begin
            unlock(lo, hi);
            check_all(lo <= hi ? "R2 sweep" : "R4 sweep");
         end
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule